// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block converts a vector of asynchronous interrupt request lines into a vector of raw pending bits. Each line has its own three configuration bits. Together they choose one of five detection kinds: active-high level, active-low level, rising edge, falling edge, or any edge.

A line in a level kind has a pending bit that copies its synchronized input, or the inverse of that input. A line in an edge kind has a pending bit that latches when the chosen transition is seen. That bit holds until a register bank outside this block sends a clear mask.

Every input passes through a synchronizer chain before it is used. The block keeps the last synchronized level of each line in every mode, so changing a line's mode never produces a spurious edge. Enable gating, priority routing and bus access belong to neighbouring blocks.

Top module: `irq_trigger_detect`

## Requirements
- R1: While reset is asserted, and after reset with all inputs low and every line in falling-edge mode, every bit of `raw_pend` is 0.
- R2: A line with `cfg_level`=1 and `cfg_active_high`=1 drives its `raw_pend` bit equal to its input. A change of the input ahead of clock edge k appears after edge k+2, where the first two edges are the synchronizer and the third is the pending register.
- R3: A line with `cfg_level`=1 and `cfg_active_high`=0 drives its `raw_pend` bit to the inverse of its input, with the same latency as R2.
- R4: A line with `cfg_level`=0, `cfg_any_edge`=0 and `cfg_active_high`=1 sets its pending bit on a 0-to-1 input transition, with the latency of R2.
- R5: A line with `cfg_level`=0, `cfg_any_edge`=0 and `cfg_active_high`=0 sets its pending bit on a 1-to-0 transition and ignores 0-to-1 transitions.
- R6: A line with `cfg_level`=0 and `cfg_any_edge`=1 sets its pending bit on a transition in either direction, whatever `cfg_active_high` holds.
- R7: For an edge-mode line, a set pending bit is never cleared by the input. It stays 1 until a clear arrives.
- R8: An `edge_clear` bit that is 1 at a clock edge clears that line's pending bit at that edge, but only when the line has `cfg_level`=0. Level-mode lines ignore `edge_clear`.
- R9: When a detected edge and a clear for the same line meet at the same clock edge, the pending bit ends at 1.
- R10: The stored previous level of each line tracks its synchronized input in every mode. A line held high in level mode and then switched to rising-edge mode sees no edge.
- R11: Under any mix of per-line modes, inputs and clear masks, the whole `raw_pend` vector follows the rules R2 to R9 cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Asynchronous interrupt request lines |
| cfg_level | input | N_LINES | 1 = level detection, 0 = edge detection, per line |
| cfg_active_high | input | N_LINES | Level mode: 1 = high active. Single-edge mode: 1 = rising, 0 = falling |
| cfg_any_edge | input | N_LINES | In edge mode, 1 = both transitions count |
| edge_clear | input | N_LINES | Per-line clear for edge-mode pending bits, acting at the clock edge it is seen |
| raw_pend | output | N_LINES | Raw pending vector |

## Verification
A wrong stored previous level shows up at the ports as a phantom or missing pending bit, and it does so one edge after the line's mode or input changes. The bench therefore switches a line from level to edge mode while its input is held high, and checks that the bit stays clear.

A wrong pending register shows up as a bit that drops without a clear, survives a clear, or loses a same-cycle edge to a clear. Each of these is visible on the very next edge. The random phase compares the whole vector against a bench model on every cycle, so any divergence is reported within one clock of its cause.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

   // Detection kind selected per line by its three configuration bits.
   typedef enum logic [2:0] {
      TRIG_LEVEL_HIGH = 3'd0,
      TRIG_LEVEL_LOW  = 3'd1,
      TRIG_EDGE_RISE  = 3'd2,
      TRIG_EDGE_FALL  = 3'd3,
      TRIG_EDGE_BOTH  = 3'd4
   } trig_kind_e;

   function automatic trig_kind_e trig_kind(input logic level_mode,
                                            input logic active_high,
                                            input logic any_edge);
      trig_kind_e k;
      if (level_mode)
         k = active_high ? TRIG_LEVEL_HIGH : TRIG_LEVEL_LOW;
      else if (any_edge)
         k = TRIG_EDGE_BOTH;
      else
         k = active_high ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
      return k;
   endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int WIDTH  = 51,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_sync_chain: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("irq_sync_chain: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[LAST];

   // R2: each stage carries the previous stage's value one clock later
   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_chk
         a_r2_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
      end
   endgenerate

endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
   import irq_trig_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_now,
   input  logic cfg_level,
   input  logic cfg_high,
   input  logic cfg_both,
   input  logic clr_req,
   output logic raw_o
);

   logic       prev_q;
   logic       raw_q;
   logic       edge_hit;
   logic       raw_d;
   trig_kind_e kind;

   always_comb begin
      kind     = trig_kind(cfg_level, cfg_high, cfg_both);
      edge_hit = 1'b0;
      raw_d    = raw_q;
      unique case (kind)
         TRIG_LEVEL_HIGH: raw_d = lvl_now;
         TRIG_LEVEL_LOW:  raw_d = ~lvl_now;
         TRIG_EDGE_RISE: begin
            edge_hit = lvl_now & ~prev_q;
            raw_d    = edge_hit | (raw_q & ~clr_req);
         end
         TRIG_EDGE_FALL: begin
            edge_hit = ~lvl_now & prev_q;
            raw_d    = edge_hit | (raw_q & ~clr_req);
         end
         TRIG_EDGE_BOTH: begin
            edge_hit = lvl_now ^ prev_q;
            raw_d    = edge_hit | (raw_q & ~clr_req);
         end
         default: raw_d = raw_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         prev_q <= lvl_now;
         raw_q  <= raw_d;
      end
   end

   assign raw_o = raw_q;

   a_r2_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level && cfg_high) |=> raw_q == $past(lvl_now));
   a_r3_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level && !cfg_high) |=> raw_q == !$past(lvl_now));
   a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level && raw_q && !clr_req) |=> raw_q);
   a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level && clr_req && (lvl_now == prev_q)) |=> !raw_q);
   a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level && cfg_both && (lvl_now != prev_q)) |=> raw_q);
   a_r10_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prev_q == $past(lvl_now));

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect #(
   parameter int N_LINES     = 51,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_in,
   input  logic [N_LINES-1:0] cfg_level,
   input  logic [N_LINES-1:0] cfg_active_high,
   input  logic [N_LINES-1:0] cfg_any_edge,
   input  logic [N_LINES-1:0] edge_clear,
   output logic [N_LINES-1:0] raw_pend
);

   generate
      if (N_LINES < 1 || N_LINES > 1024) begin : g_bad_lines
         $error("irq_trigger_detect: N_LINES out of range");
      end
   endgenerate

   logic [N_LINES-1:0] line_sync;

   irq_sync_chain #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (line_in),
      .dout  (line_sync)
   );

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         irq_trig_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_now   (line_sync[i]),
            .cfg_level (cfg_level[i]),
            .cfg_high  (cfg_active_high[i]),
            .cfg_both  (cfg_any_edge[i]),
            .clr_req   (edge_clear[i]),
            .raw_o     (raw_pend[i])
         );
      end
   endgenerate

endmodule

// File: tb/irq_trigger_detect_bench.sv
`timescale 1ns/1ps
module irq_trigger_detect_bench;

   localparam int N = 51;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] line_in = '0;
   logic [N-1:0] cfg_level = '0;
   logic [N-1:0] cfg_active_high = '0;
   logic [N-1:0] cfg_any_edge = '0;
   logic [N-1:0] edge_clear = '0;
   logic [N-1:0] raw_pend;

   int errors = 0;
   int checks = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_trigger_detect #(.N_LINES(N), .SYNC_STAGES(2)) u_irq_trigger_detect (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_in         (line_in),
      .cfg_level       (cfg_level),
      .cfg_active_high (cfg_active_high),
      .cfg_any_edge    (cfg_any_edge),
      .edge_clear      (edge_clear),
      .raw_pend        (raw_pend)
   );

   // Bench model built from the requirements: two sync flops, previous level, pending
   logic [N-1:0] m_s1, m_s2, m_prev, m_raw;

   function automatic logic [N-1:0] next_raw(input logic [N-1:0] lv, input logic [N-1:0] pv,
                                             input logic [N-1:0] rw, input logic [N-1:0] lvl,
                                             input logic [N-1:0] hi, input logic [N-1:0] both,
                                             input logic [N-1:0] clr);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (lvl[i]) r[i] = hi[i] ? lv[i] : ~lv[i];
         else begin
            logic hit;
            if (both[i]) hit = lv[i] != pv[i];
            else if (hi[i]) hit = lv[i] && !pv[i];
            else hit = !lv[i] && pv[i];
            r[i] = hit | (rw[i] & ~clr[i]);
         end
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0;
      end else begin
         m_raw  <= next_raw(m_s2, m_prev, m_raw, cfg_level, cfg_active_high, cfg_any_edge, edge_clear);
         m_prev <= m_s2;
         m_s2   <= m_s1;
         m_s1   <= line_in;
      end
   end

   always @(negedge clk) begin
      if (model_on && rst_n && !done) begin
         checks++;
         if (raw_pend !== m_raw) begin
            errors++;
            $display("FAIL R11 model vector: actual=%h expected=%h", raw_pend, m_raw);
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      edge_clear = '1;
      step(1);
      edge_clear = '0;
   endtask

   task automatic set_mode(input int i, input logic lvl, input logic hi, input logic both);
      cfg_level[i] = lvl;
      cfg_active_high[i] = hi;
      cfg_any_edge[i] = both;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      // R1: reset state, inputs high during reset
      line_in = '1;
      step(3);
      checks++;
      if (raw_pend !== '0) begin errors++; $display("FAIL R1 in reset: actual=%h expected=0", raw_pend); end
      line_in = '0;
      step(4);
      rst_n = 1'b1;
      step(4);
      checks++;
      if (raw_pend !== '0) begin errors++; $display("FAIL R1 after reset: actual=%h expected=0", raw_pend); end

      // R4 rising edge, latency, R7 sticky, R8 clear
      set_mode(5, 1'b0, 1'b1, 1'b0);
      step(4); clear_all();
      chk("R4 idle", raw_pend[5], 1'b0);
      line_in[5] = 1'b1;
      step(2); chk("R4 latency not yet", raw_pend[5], 1'b0);
      step(1); chk("R4 rise sets", raw_pend[5], 1'b1);
      line_in[5] = 1'b0;
      step(5); chk("R7 sticky after input drop", raw_pend[5], 1'b1);
      edge_clear[5] = 1'b1; step(1); edge_clear[5] = 1'b0;
      chk("R8 edge clear", raw_pend[5], 1'b0);

      // R5 falling edge
      set_mode(12, 1'b0, 1'b0, 1'b0);
      line_in[12] = 1'b1;
      step(4); clear_all();
      step(2);
      chk("R5 rise ignored", raw_pend[12], 1'b0);
      line_in[12] = 1'b0;
      step(3); chk("R5 fall sets", raw_pend[12], 1'b1);

      // R6 both edges
      set_mode(20, 1'b0, 1'b0, 1'b1);
      step(4); clear_all();
      line_in[20] = 1'b1;
      step(3); chk("R6 rise sets", raw_pend[20], 1'b1);
      clear_all(); chk("R6 cleared", raw_pend[20], 1'b0);
      line_in[20] = 1'b0;
      step(3); chk("R6 fall sets", raw_pend[20], 1'b1);

      // R2 level high with latency
      set_mode(30, 1'b1, 1'b1, 1'b0);
      step(4); chk("R2 low input", raw_pend[30], 1'b0);
      line_in[30] = 1'b1;
      step(2); chk("R2 latency not yet", raw_pend[30], 1'b0);
      step(1); chk("R2 follows high", raw_pend[30], 1'b1);
      line_in[30] = 1'b0;
      step(3); chk("R2 follows low", raw_pend[30], 1'b0);

      // R3 level low
      set_mode(31, 1'b1, 1'b0, 1'b0);
      step(3); chk("R3 low input gives 1", raw_pend[31], 1'b1);
      line_in[31] = 1'b1;
      step(3); chk("R3 high input gives 0", raw_pend[31], 1'b0);

      // R8 level line ignores clear
      line_in[30] = 1'b1;
      step(3);
      edge_clear[30] = 1'b1; step(3);
      chk("R8 level ignores clear", raw_pend[30], 1'b1);
      edge_clear[30] = 1'b0;

      // R9 edge and clear in the same cycle
      set_mode(40, 1'b0, 1'b0, 1'b1);
      step(4); clear_all();
      line_in[40] = 1'b1;
      step(2);
      edge_clear[40] = 1'b1; step(1); edge_clear[40] = 1'b0;
      chk("R9 edge beats clear", raw_pend[40], 1'b1);

      // R10 previous level tracked while in level mode
      set_mode(44, 1'b1, 1'b1, 1'b0);
      line_in[44] = 1'b1;
      step(4); chk("R10 level high first", raw_pend[44], 1'b1);
      set_mode(44, 1'b0, 1'b1, 1'b0);
      edge_clear[44] = 1'b1; step(1); edge_clear[44] = 1'b0;
      chk("R10 no edge on mode switch", raw_pend[44], 1'b0);
      step(3); chk("R10 still clear", raw_pend[44], 1'b0);

      // R11 random mix against the bench model
      model_on = 1'b1;
      for (int c = 0; c < 3000; c++) begin
         if (c % 64 == 0) begin
            cfg_level       = {$urandom, $urandom};
            cfg_active_high = {$urandom, $urandom};
            cfg_any_edge    = {$urandom, $urandom};
         end
         if ($urandom_range(0, 3) != 0) line_in = line_in ^ ({$urandom, $urandom} & {$urandom, $urandom});
         edge_clear = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         step(1);
      end
      edge_clear = '0;
      step(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule